// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block serialises parallel bytes into asynchronous serial frames on a single TX line. A byte is offered on a valid/ready handshake; once taken, the block sends a low start bit, the data bits least significant first, an optional parity bit and a stop period, then returns to the idle-high line and asks for the next byte. Bit timing comes from an external baud tick that pulses at sixteen times the bit rate. Every bit lasts sixteen ticks.

The frame format is set by a small group of line-control inputs:
- the number of data bits, from five to eight;
- one stop bit or the longer stop period;
- parity off, odd, even, or forced to a fixed level.

These fields are captured when a byte is accepted, so software may rewrite them while a frame is on the wire. A separate break input overrides the line to low for as long as it is set, without disturbing the frame sequencing underneath.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, tx_line is 1, tx_busy is 0 and in_ready is 1.
- R2: in_ready is 1 exactly while no frame is in progress. A byte is taken on a clock edge where in_valid and in_ready are both 1. tx_line and tx_busy follow the frame one clock after that edge.
- R3: The line idles at 1. Each frame begins with one start bit at 0, and every start, data and parity bit lasts 16 baud ticks.
- R4: Data bits go out least significant bit first. The cfg_len field sets the count: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Unused upper bits of in_data are not sent.
- R5: With cfg_stop_sel at 0, the frame ends with one stop bit at 1 lasting 16 ticks, at any word length.
- R6: With cfg_stop_sel at 1 and 5-bit words, the stop period is 1.5 bits (24 ticks) at 1.
- R7: With cfg_stop_sel at 1 and 6, 7 or 8-bit words, the stop period is two bits (32 ticks) at 1.
- R8: With cfg_par_en at 0, no parity bit is sent and the stop period follows the last data bit directly.
- R9: With cfg_par_en at 1 and cfg_par_force at 0, one parity bit follows the data. With cfg_par_even at 0 it makes the count of ones over data and parity odd; with cfg_par_even at 1 it makes that count even.
- R10: With cfg_par_en at 1 and cfg_par_force at 1, the parity bit is fixed. It is 1 when cfg_par_even is 0 and 0 when cfg_par_even is 1.
- R11: While cfg_break is 1, tx_line is 0 from the next clock onward, idle or not. A frame in progress keeps its timing and tx_busy. tx_line is released one clock after cfg_break returns to 0.
- R12: The line-control fields are sampled when a byte is accepted. Changing them during a frame has no effect on that frame.
- R13: tx_busy is 1 for the whole frame and drops when the stop period ends. The frame lasts 16·(1+data bits+parity bit) ticks plus the stop period, less at most one tick period for the phase of the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| in_data | input | DATA_W | Byte to transmit |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Transmitter can take a byte |
| cfg_len | input | 2 | Word length select (00=5 … 11=8 bits) |
| cfg_stop_sel | input | 1 | 0: one stop bit, 1: 1.5 or 2 stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Parity type / forced level select |
| cfg_par_force | input | 1 | Fixed parity level |
| cfg_break | input | 1 | Hold the line low |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | Frame in progress |

## Verification
Two functions can coincide in one cycle.
- Break forcing and frame sequencing: the bench raises cfg_break partway through a frame and requires the line to stay low to the end. The tx_busy window must still have the length the latched format implies.
- Acceptance and a format rewrite: the bench rewrites every line-control field on the clock after acceptance. The decoded bits, the parity and the frame length must still match the format seen at acceptance.

Both cases are judged against bit positions and durations the bench computes from the tick period, across every word length, stop and parity combination.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    STOP_ONE  = 2'd0,
    STOP_HALF = 2'd1,
    STOP_TWO  = 2'd2
  } stop_kind_e;

  localparam int NB_W = 4;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    stop_kind_e      stop_kind;
    logic            par_en;
  } frame_fmt_t;

endpackage

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
  import uart_tx_pkg::*;
(
  input  logic [1:0] len_sel,
  input  logic       stop_sel,
  input  logic       par_en,
  output frame_fmt_t fmt
);
  localparam logic [NB_W-1:0] MIN_BITS = NB_W'(5);

  always_comb begin
    fmt.nbits  = MIN_BITS + NB_W'(len_sel);
    fmt.par_en = par_en;
    if (!stop_sel)
      fmt.stop_kind = STOP_ONE;
    else if (len_sel == 2'b00)
      fmt.stop_kind = STOP_HALF;
    else
      fmt.stop_kind = STOP_TWO;
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [NB_W-1:0]   nbits,
  input  logic              even_sel,
  input  logic              force_sel,
  output logic              par_bit
);
  logic [DATA_W-1:0] masked;
  logic              xor_all;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] & (NB_W'(i) < nbits);
  end

  assign xor_all = ^masked;

  always_comb begin
    if (force_sel)
      par_bit = ~even_sel;
    else if (even_sel)
      par_bit = xor_all;
    else
      par_bit = ~xor_all;
  end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  frame_fmt_t        fmt,
  input  logic              par_bit,
  output logic              idle,
  output logic              line_bit
);
  localparam int TCW = $clog2(2 * OS);
  localparam int LW  = TCW + 1;
  localparam int IW  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [LW-1:0] LEN_BIT  = LW'(OS);
  localparam logic [LW-1:0] LEN_HALF = LW'(OS + OS / 2);
  localparam logic [LW-1:0] LEN_TWO  = LW'(2 * OS);

  tx_state_e         state;
  logic [TCW-1:0]    cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  frame_fmt_t        fmt_q;
  logic              par_q;
  logic [LW-1:0]     stop_len;
  logic [LW-1:0]     limit;
  logic              bit_end;
  logic              last_data;

  always_comb begin
    case (fmt_q.stop_kind)
      STOP_HALF: stop_len = LEN_HALF;
      STOP_TWO:  stop_len = LEN_TWO;
      default:   stop_len = LEN_BIT;
    endcase
    limit     = (state == ST_STOP) ? stop_len : LEN_BIT;
    bit_end   = tick && ({1'b0, cnt} == limit - LW'(1));
    last_data = ((NB_W'(idx) + NB_W'(1)) == fmt_q.nbits);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      fmt_q <= '{nbits: NB_W'(5), stop_kind: STOP_ONE, par_en: 1'b0};
      par_q <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state <= ST_START;
        cnt   <= '0;
        idx   <= '0;
        shreg <= data;
        fmt_q <= fmt;
        par_q <= par_bit;
      end
    end else if (tick) begin
      if (bit_end) begin
        cnt <= '0;
        case (state)
          ST_START: begin
            state <= ST_DATA;
            idx   <= '0;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (last_data)
              state <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else
              idx <= idx + IW'(1);
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + TCW'(1);
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: line_bit = 1'b0;
      ST_DATA:  line_bit = shreg[0];
      ST_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  assign idle = (state == ST_IDLE);

  // R4: the data phase ends only after the latched number of bits
  a_r4_bit_count: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DATA && state != ST_DATA)
      |-> ((NB_W'($past(idx)) + NB_W'(1)) == $past(fmt_q.nbits)));

  // R12: the latched format cannot move while a frame runs
  a_r12_fmt_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(fmt_q));

  // R6/R7: the stop counter stays inside the stop period
  a_r6_stop_cap: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> ({1'b0, cnt} < stop_len));

  // R8: with parity off, the data phase never leads to a parity bit
  a_r8_no_par: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_DATA && !fmt_q.par_en) |-> (state != ST_PAR));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop_sel,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_force,
  input  logic              cfg_break,
  output logic              tx_line,
  output logic              tx_busy
);
  frame_fmt_t fmt;
  logic       par_bit;
  logic       seq_idle;
  logic       seq_line;
  logic       accept;

  uart_tx_fmt u_fmt (
    .len_sel  (cfg_len),
    .stop_sel (cfg_stop_sel),
    .par_en   (cfg_par_en),
    .fmt      (fmt)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data      (in_data),
    .nbits     (fmt.nbits),
    .even_sel  (cfg_par_even),
    .force_sel (cfg_par_force),
    .par_bit   (par_bit)
  );

  uart_tx_seq #(.DATA_W(DATA_W), .OS(OS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick),
    .start    (accept),
    .data     (in_data),
    .fmt      (fmt),
    .par_bit  (par_bit),
    .idle     (seq_idle),
    .line_bit (seq_line)
  );

  assign in_ready = seq_idle;
  assign accept   = in_valid && seq_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_line <= 1'b1;
      tx_busy <= 1'b0;
    end else begin
      tx_line <= cfg_break ? 1'b0 : seq_line;
      tx_busy <= !seq_idle;
    end
  end

  // R11: break pulls the line low on the next clock
  a_r11_break_low: assert property (@(posedge clk) disable iff (rst)
    cfg_break |=> !tx_line);

  // R2: an accepted byte closes the ready window
  a_r2_accept_closes: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R3: the line is high whenever no frame and no break drove it
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!tx_busy && !$past(cfg_break)) |-> tx_line);

  // R13: busy follows the sequencer one clock later
  a_r13_busy_track: assert property (@(posedge clk) disable iff (rst)
    $past(!in_ready) |-> tx_busy);
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int T = 2;

  logic       clk = 0;
  logic       rst = 1;
  logic       baud_tick = 0;
  logic [7:0] in_data = '0;
  logic       in_valid = 0;
  logic       in_ready;
  logic [1:0] cfg_len = '0;
  logic       cfg_stop_sel = 0, cfg_par_en = 0, cfg_par_even = 0, cfg_par_force = 0;
  logic       cfg_break = 0;
  logic       tx_line, tx_busy;

  int tests = 0, fails = 0;
  bit done = 0;
  int tick_div = 0;
  logic line_log [0:1023];

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    tick_div  <= (tick_div == T - 1) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == T - 1);
  end

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_len(cfg_len),
    .cfg_stop_sel(cfg_stop_sel), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_force(cfg_par_force),
    .cfg_break(cfg_break), .tx_line(tx_line), .tx_busy(tx_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pm: 0 off, 1 odd, 2 even, 3 forced with even_sel 0, 4 forced with even_sel 1
  task automatic send(input logic [7:0] d, input int len, input int stp, input int pm,
                      input bit scramble, input int brk_at);
    int nb, stop_t, n_ticks, c, offset, ones, k, s, pos;
    bit pen, pbit;
    string tag;
    @(negedge clk);
    in_data = d; in_valid = 1; cfg_len = 2'(len); cfg_stop_sel = stp[0];
    cfg_par_en = (pm != 0); cfg_par_even = (pm == 2 || pm == 4);
    cfg_par_force = (pm >= 3);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    if (scramble) begin   // R12: rewrite every field after acceptance
      cfg_len = ~cfg_len; cfg_stop_sel = ~cfg_stop_sel; cfg_par_en = ~cfg_par_en;
      cfg_par_even = ~cfg_par_even; cfg_par_force = ~cfg_par_force;
    end
    while (!tx_busy) @(negedge clk);
    c = 0;
    while (tx_busy && c < 1024) begin
      line_log[c] = tx_line;
      if (c == 0) check(!in_ready, "R2 ready low in frame", int'(in_ready), 0);
      if (c == brk_at) cfg_break = 1;
      c++;
      @(negedge clk);
    end
    nb = 5 + len;
    pen = (pm != 0);
    stop_t = (stp == 0) ? 16 : (nb == 5 ? 24 : 32);
    n_ticks = 16 * (1 + nb + int'(pen)) + stop_t;
    tag = (stp == 0) ? "R5" : (nb == 5 ? "R6" : "R7");
    check(c >= (n_ticks - 1) * T + 1 && c <= n_ticks * T,
          $sformatf("R13 %s %s frame clocks len=%0d stp=%0d pm=%0d", tag, pen ? "R9" : "R8",
                    len, stp, pm), c, n_ticks * T);
    offset = c - n_ticks * T;
    if (brk_at >= 0) begin
      for (int i = brk_at + 1; i < c; i++)
        if (line_log[i] !== 1'b0) begin
          check(0, "R11 break holds line low", int'(line_log[i]), 0);
          break;
        end
      check(1, "R11 break window", 0, 0);
      @(negedge clk);
      check(tx_line === 1'b0, "R11 break while idle", int'(tx_line), 0);
      cfg_break = 0;
      @(negedge clk);
      check(tx_line === 1'b1, "R11 release", int'(tx_line), 1);
    end else begin
      ones = 0;
      for (int i = 0; i < nb; i++) ones += int'(d[i]);
      if (pm == 1) pbit = (ones % 2 == 0);
      else if (pm == 2) pbit = (ones % 2 == 1);
      else pbit = (pm == 3);
      s = 0;
      for (k = 0; k < 2 + nb + int'(pen); k++) begin
        pos = (s + 8) * T + offset;
        if (k == 0)
          check(line_log[pos] === 1'b0, "R3 start bit", int'(line_log[pos]), 0);
        else if (k <= nb)
          check(line_log[pos] === d[k-1], $sformatf("R4 data bit %0d", k - 1),
                int'(line_log[pos]), int'(d[k-1]));
        else if (pen && k == nb + 1)
          check(line_log[pos] === pbit, (pm >= 3) ? "R10 forced parity" : "R9 parity",
                int'(line_log[pos]), int'(pbit));
        else begin
          check(line_log[pos] === 1'b1, {tag, " stop level"}, int'(line_log[pos]), 1);
          pos = (s + stop_t - 2) * T + offset;
          check(line_log[pos] === 1'b1, {tag, " stop tail"}, int'(line_log[pos]), 1);
        end
        s += 16;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(tx_line === 1'b1, "R1 reset line", int'(tx_line), 1);
    check(tx_busy === 1'b0, "R1 reset busy", int'(tx_busy), 0);
    check(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
    for (int len = 0; len < 4; len++)
      for (int stp = 0; stp < 2; stp++)
        for (int pm = 0; pm < 5; pm++) begin
          logic [7:0] d = 8'h5A ^ 8'((len * 10 + stp * 5 + pm) * 37);
          send(d, len, stp, pm, 0, -1);
          send(~d, len, stp, pm, 1, -1);
        end
    send(8'hFF, 3, 1, 2, 0, 40);    // R11 break mid-frame
    send(8'h00, 0, 1, 1, 1, 100);   // R11 with R12 rewrite
    send(8'hE1, 0, 0, 4, 0, -1);    // R4 upper bits ignored for 5-bit words
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule